// File: doc/BRIEF.md
# Ping-pong clock root selector

This block is one clock root slice that runs in a single system clock domain. Each of eight source clocks arrives as a one-cycle enable strobe. The slice produces one divided enable strobe from these. Inside there are two branches. Each branch has its own source selector, its own gate and its own pre-divider. A final branch mux picks one branch and feeds a shared post-divider. Software sees a simple interface. A configuration write sets the enable bit and both divider fields. A selection write gives a source index.

Every accepted selection write loads the index into the branch that is not driving the output. The block then moves the output over to that branch at a safe boundary. An internal toggle records which branch drives the output. If software writes the same index twice in a row, both branches sit on that source, and the previous source can then be stopped without harm. The block watches the source of each branch. A write that lands on a branch whose current source has stopped raises a stale flag. A build option removes the pre-dividers so that each branch path runs straight from its gate to the mux.

Controller states: `SW_IDLE` (no switch pending) and `SW_PEND` (a branch was just loaded and the flip is waiting for a boundary). Transitions: `SW_IDLE -> SW_PEND` on an accepted selection write. `SW_PEND -> SW_IDLE` in the first cycle in which both branch strobes are low. That cycle also flips the active branch.

Top module: `ckroot_pingpong`

## Requirements
- R1: After reset both branches hold source 0, branch A is active (`stat_active`=0), `stat_busy`=0, `stat_stale`=0, the enable bit is clear so `out_stb` stays low, and both divider fields are 0.
- R2: The selector has eight sources indexed 0..7 by a 3-bit `sel_idx`. A branch set to index i follows `src_stb[i]`.
- R3: A selection write made while `stat_busy`=0 loads only the inactive branch (branch B when `stat_active`=0, branch A when it is 1). `stat_busy` reads 1 on the next cycle. `stat_active` then flips and `stat_busy` clears.
- R4: Two accepted selection writes of the same index leave both `stat_src_a` and `stat_src_b` equal to that index.
- R5: A selection write sampled while `stat_busy`=1 is ignored. Neither branch source changes because of it.
- R6: `cfg_pre` and `cfg_post` each hold a divide ratio minus one, from 1 to 8. With an evenly spaced source of period P cycles, `out_stb` pulses once every P*(cfg_pre+1)*(cfg_post+1) cycles.
- R7: With `CORE_ONLY`=1 the pre-divide stage is absent, and the output period is P*(cfg_post+1) whatever `cfg_pre` holds.
- R8: A configuration write with `cfg_en`=0 holds `out_stb` low from the next cycle on. Branch sources and the active bit are kept. Setting the enable again resumes output at the same period.
- R9: On each accepted selection write, `stat_stale` is set to 1 if the targeted branch's current source has given no strobe for at least `IDLE_LIMIT` cycles, and to 0 otherwise.
- R10: The active branch changes only at the end of a cycle in which both branch strobes are low, so no output pulse is cut short or doubled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_stb | input | NSRC | Source clock enable strobes |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_en | input | 1 | Output enable bit |
| cfg_pre | input | DIVW | Pre-divide ratio minus one |
| cfg_post | input | DIVW | Post-divide ratio minus one |
| sel_we | input | 1 | Selection write strobe |
| sel_idx | input | log2(NSRC) | Source index to select |
| out_stb | output | 1 | Divided output strobe |
| stat_src_a | output | log2(NSRC) | Source held by branch A |
| stat_src_b | output | log2(NSRC) | Source held by branch B |
| stat_active | output | 1 | Branch driving the output (0 = A) |
| stat_busy | output | 1 | A branch switch is pending |
| stat_stale | output | 1 | Last accepted write targeted an idle source |

## Verification
The bench repeats the same index twice. A design that loaded the active branch, or that never reached the inactive one, would leave the old source in one branch. It issues a second write while the first switch is still pending. A design that accepted that write would load a new source into the branch that was just programmed. It measures the period at the extreme divider settings and in the core-only build. A wrong field offset, or a pre-divider that was not removed, would show as a wrong pulse interval. It also stops a source on the inactive branch before a write, and a broken idle timer would then miss the stale flag or raise it on a live source.

// File: rtl/ckroot_pkg.sv
package ckroot_pkg;

    typedef enum logic {
        SW_IDLE = 1'b0,
        SW_PEND = 1'b1
    } sw_state_e;

    localparam int unsigned BRANCHES = 2;

endpackage

// File: rtl/ckroot_div.sv
module ckroot_div #(
    parameter int unsigned W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         stb_i,
    input  logic [W-1:0] lim,
    output logic         stb_o
);

    logic [W-1:0] cnt_q;

    // Terminal count also fires when lim was lowered below the count.
    assign stb_o = stb_i && (cnt_q >= lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (stb_i) begin
            cnt_q <= (cnt_q >= lim) ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/ckroot_branch.sv
module ckroot_branch #(
    parameter int unsigned NSRC       = 8,
    parameter int unsigned DIVW       = 3,
    parameter bit          HAS_PRE    = 1'b1,
    parameter int unsigned IDLE_LIMIT = 32,
    localparam int unsigned SELW      = $clog2(NSRC),
    localparam int unsigned IW        = $clog2(IDLE_LIMIT + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_stb,
    input  logic            load,
    input  logic [SELW-1:0] load_sel,
    input  logic            gate_en,
    input  logic [DIVW-1:0] pre_lim,
    output logic [SELW-1:0] sel_o,
    output logic            dstb_o,
    output logic            stale_o
);

    logic [SELW-1:0] sel_q;
    logic [IW-1:0]   idle_q;
    logic            raw_stb;
    logic            gated_stb;

    assign raw_stb   = src_stb[sel_q];
    assign gated_stb = raw_stb & gate_en;
    assign sel_o     = sel_q;
    assign stale_o   = (idle_q == IW'(IDLE_LIMIT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (load) begin
            sel_q <= load_sel;
        end
    end

    // Cycles since the current source last strobed, saturating.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_q <= '0;
        end else if (load || raw_stb) begin
            idle_q <= '0;
        end else if (idle_q != IW'(IDLE_LIMIT)) begin
            idle_q <= idle_q + 1'b1;
        end
    end

    generate
        if (HAS_PRE) begin : g_pre
            ckroot_div #(.W(DIVW)) u_pre (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (load),
                .stb_i (gated_stb),
                .lim   (pre_lim),
                .stb_o (dstb_o)
            );
        end else begin : g_nopre
            logic unused_pre;
            assign unused_pre = ^pre_lim;
            assign dstb_o     = gated_stb;
        end
    endgenerate

endmodule

// File: rtl/ckroot_ctrl.sv
module ckroot_ctrl
    import ckroot_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel_we,
    input  logic dstb_a,
    input  logic dstb_b,
    input  logic stale_a,
    input  logic stale_b,
    output logic load_a,
    output logic load_b,
    output logic active,
    output logic busy,
    output logic stale
);

    sw_state_e state_q;
    sw_state_e state_d;
    logic      active_q;
    logic      stale_q;
    logic      flip;
    logic      accept;

    // Next state and outputs.
    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        flip    = 1'b0;
        unique case (state_q)
            SW_IDLE: begin
                if (sel_we) begin
                    accept  = 1'b1;
                    state_d = SW_PEND;
                end
            end
            SW_PEND: begin
                if (!dstb_a && !dstb_b) begin
                    flip    = 1'b1;
                    state_d = SW_IDLE;
                end
            end
            default: state_d = SW_IDLE;
        endcase
        load_a = accept &&  active_q;
        load_b = accept && !active_q;
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= SW_IDLE;
            active_q <= 1'b0;
            stale_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (flip) begin
                active_q <= ~active_q;
            end
            if (accept) begin
                stale_q <= active_q ? stale_a : stale_b;
            end
        end
    end

    assign active = active_q;
    assign busy   = (state_q == SW_PEND);
    assign stale  = stale_q;

endmodule

// File: rtl/ckroot_pingpong.sv
module ckroot_pingpong #(
    parameter int unsigned NSRC       = 8,
    parameter int unsigned DIVW       = 3,
    parameter bit          CORE_ONLY  = 1'b0,
    parameter int unsigned IDLE_LIMIT = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NSRC-1:0]          src_stb,
    input  logic                     cfg_we,
    input  logic                     cfg_en,
    input  logic [DIVW-1:0]          cfg_pre,
    input  logic [DIVW-1:0]          cfg_post,
    input  logic                     sel_we,
    input  logic [$clog2(NSRC)-1:0]  sel_idx,
    output logic                     out_stb,
    output logic [$clog2(NSRC)-1:0]  stat_src_a,
    output logic [$clog2(NSRC)-1:0]  stat_src_b,
    output logic                     stat_active,
    output logic                     stat_busy,
    output logic                     stat_stale
);

    import ckroot_pkg::*;

    localparam int unsigned SELW = $clog2(NSRC);

    logic            en_q;
    logic [DIVW-1:0] pre_q;
    logic [DIVW-1:0] post_q;
    logic [BRANCHES-1:0] load;
    logic [BRANCHES-1:0] dstb;
    logic [BRANCHES-1:0] stale;
    logic [SELW-1:0]     bsel [BRANCHES];
    logic            mux_stb;
    logic            post_stb;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            pre_q  <= '0;
            post_q <= '0;
        end else if (cfg_we) begin
            en_q   <= cfg_en;
            pre_q  <= cfg_pre;
            post_q <= cfg_post;
        end
    end

    generate
        for (genvar g = 0; g < BRANCHES; g++) begin : g_br
            ckroot_branch #(
                .NSRC       (NSRC),
                .DIVW       (DIVW),
                .HAS_PRE    (!CORE_ONLY),
                .IDLE_LIMIT (IDLE_LIMIT)
            ) u_branch (
                .clk      (clk),
                .rst_n    (rst_n),
                .src_stb  (src_stb),
                .load     (load[g]),
                .load_sel (sel_idx),
                .gate_en  (en_q),
                .pre_lim  (pre_q),
                .sel_o    (bsel[g]),
                .dstb_o   (dstb[g]),
                .stale_o  (stale[g])
            );
        end
    endgenerate

    ckroot_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_we  (sel_we),
        .dstb_a  (dstb[0]),
        .dstb_b  (dstb[1]),
        .stale_a (stale[0]),
        .stale_b (stale[1]),
        .load_a  (load[0]),
        .load_b  (load[1]),
        .active  (stat_active),
        .busy    (stat_busy),
        .stale   (stat_stale)
    );

    assign mux_stb = stat_active ? dstb[1] : dstb[0];

    ckroot_div #(.W(DIVW)) u_post (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (1'b0),
        .stb_i (mux_stb),
        .lim   (post_q),
        .stb_o (post_stb)
    );

    assign out_stb    = post_stb & en_q;
    assign stat_src_a = bsel[0];
    assign stat_src_b = bsel[1];

endmodule

// File: rtl/ckroot_pingpong_chk.sv
module ckroot_pingpong_chk #(
    parameter int unsigned SELW = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_we,
    input logic            cfg_en,
    input logic            sel_we,
    input logic            out_stb,
    input logic [SELW-1:0] stat_src_a,
    input logic [SELW-1:0] stat_src_b,
    input logic            stat_active,
    input logic            stat_busy,
    input logic            dstb_a,
    input logic            dstb_b
);

    // R3: an accepted write makes the slice busy next cycle
    p_accept_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_we && !stat_busy) |=> stat_busy);

    // R3: the active branch keeps its source across an accepted write
    p_active_a_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_we && !stat_busy && !stat_active) |=> $stable(stat_src_a));

    p_active_b_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_we && !stat_busy && stat_active) |=> $stable(stat_src_b));

    // R5: a write during a pending switch changes no branch source
    p_busy_ignore_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_we && stat_busy) |=> ($stable(stat_src_a) && $stable(stat_src_b)));

    // R8: clearing the enable silences the output on the next cycle
    p_disable_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_en) |=> !out_stb);

    // R10: the branch mux moves only after a cycle with both strobes low
    p_flip_boundary_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_active != $past(stat_active)) |-> (!$past(dstb_a) && !$past(dstb_b)));

    // R3: the active bit changes only while a switch is pending
    p_flip_only_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_active != $past(stat_active)) |-> $past(stat_busy));

endmodule

bind ckroot_pingpong ckroot_pingpong_chk #(.SELW($clog2(NSRC))) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_en      (cfg_en),
    .sel_we      (sel_we),
    .out_stb     (out_stb),
    .stat_src_a  (stat_src_a),
    .stat_src_b  (stat_src_b),
    .stat_active (stat_active),
    .stat_busy   (stat_busy),
    .dstb_a      (dstb[0]),
    .dstb_b      (dstb[1])
);

// File: tb/tb_ckroot_pingpong.sv
module tb_ckroot_pingpong;

    localparam int NSRC = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src_stb = '0;
    logic [NSRC-1:0] alive = '1;
    logic            cfg_we = 1'b0;
    logic            cfg_en = 1'b0;
    logic [2:0]      cfg_pre = '0;
    logic [2:0]      cfg_post = '0;
    logic            sel_we = 1'b0;
    logic [2:0]      sel_idx = '0;
    logic            out_stb, out_core;
    logic [2:0]      src_a, src_b, src_a_c, src_b_c;
    logic            active, busy, stale, active_c, busy_c, stale_c;

    int vectors = 0;
    int fails = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    ckroot_pingpong dut (
        .clk(clk), .rst_n(rst_n), .src_stb(src_stb),
        .cfg_we(cfg_we), .cfg_en(cfg_en), .cfg_pre(cfg_pre), .cfg_post(cfg_post),
        .sel_we(sel_we), .sel_idx(sel_idx), .out_stb(out_stb),
        .stat_src_a(src_a), .stat_src_b(src_b), .stat_active(active),
        .stat_busy(busy), .stat_stale(stale)
    );

    ckroot_pingpong #(.CORE_ONLY(1'b1)) dut_core (
        .clk(clk), .rst_n(rst_n), .src_stb(src_stb),
        .cfg_we(cfg_we), .cfg_en(cfg_en), .cfg_pre(cfg_pre), .cfg_post(cfg_post),
        .sel_we(sel_we), .sel_idx(sel_idx), .out_stb(out_core),
        .stat_src_a(src_a_c), .stat_src_b(src_b_c), .stat_active(active_c),
        .stat_busy(busy_c), .stat_stale(stale_c)
    );

    // Source i strobes once every i+2 cycles while alive.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        #2;
        for (int i = 0; i < NSRC; i++) begin
            src_stb[i] = alive[i] && ((cyc % (i + 2)) == 0);
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int expv);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, expv);
        end
    endtask

    task automatic chk_status(input string tag, input int ea, input int eb, input int eact);
        chk(src_a == 3'(ea), tag, "src_a", src_a, ea);
        chk(src_b == 3'(eb), tag, "src_b", src_b, eb);
        chk(active == 1'(eact), tag, "active", active, eact);
    endtask

    // Scoreboard: expected output intervals.
    int    exp_q[$];
    string cur_tag = "";
    bit    armed = 1'b0;
    bit    first = 1'b0;
    int    last_t = 0;

    always @(negedge clk) begin
        if (armed && out_stb) begin
            if (first) begin
                first = 1'b0;
                last_t = cyc;
            end else begin
                int e;
                e = exp_q.pop_front();
                chk((cyc - last_t) == e, cur_tag, "interval", cyc - last_t, e);
                last_t = cyc;
                if (exp_q.size() == 0) armed = 1'b0;
            end
        end
    end

    task automatic expect_period(input int p, input int n, input string tag);
        repeat (2 * p + 4) @(posedge clk);
        cur_tag = tag;
        for (int i = 0; i < n; i++) exp_q.push_back(p);
        first = 1'b1;
        armed = 1'b1;
        wait (armed == 1'b0);
    endtask

    task automatic core_period(input int p, input string tag);
        int t0;
        repeat (2 * p + 4) @(posedge clk);
        @(negedge clk);
        while (!out_core) @(negedge clk);
        t0 = cyc;
        @(negedge clk);
        while (!out_core) @(negedge clk);
        chk((cyc - t0) == p, tag, "core interval", cyc - t0, p);
    endtask

    task automatic cfg_write(input bit en, input int pre, input int post);
        @(posedge clk); #2;
        cfg_we = 1'b1; cfg_en = en; cfg_pre = 3'(pre); cfg_post = 3'(post);
        @(posedge clk); #2;
        cfg_we = 1'b0;
    endtask

    task automatic sel_write(input int idx);
        @(posedge clk); #2;
        sel_we = 1'b1; sel_idx = 3'(idx);
        @(posedge clk); #2;
        sel_we = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got %0d expected %0d", cyc, 0);
        finish_run();
    end

    initial begin
        int pulses;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk_status("R1", 0, 0, 0);
        chk(busy == 1'b0, "R1", "busy", busy, 0);
        chk(stale == 1'b0, "R1", "stale", stale, 0);
        pulses = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (out_stb) pulses++;
        end
        chk(pulses == 0, "R1", "pulses while disabled", pulses, 0);

        // R2 / R6: source 0, divide by 1 -> period 2
        cfg_write(1'b1, 0, 0);
        expect_period(2, 4, "R2");

        // R3: write 3 lands on B, busy next cycle, then active flips
        @(posedge clk); #2;
        sel_we = 1'b1; sel_idx = 3'd3;
        @(posedge clk); #2;
        sel_we = 1'b0;
        chk(busy == 1'b1, "R3", "busy after write", busy, 1);
        repeat (6) @(negedge clk);
        chk_status("R3", 0, 3, 1);
        chk(busy == 1'b0, "R3", "busy cleared", busy, 0);
        cfg_write(1'b1, 0, 1);
        expect_period(10, 3, "R6");

        // R4: the same index again puts both branches on source 3
        sel_write(3);
        repeat (6) @(negedge clk);
        chk_status("R4", 3, 3, 0);

        // R5: a second write while busy is dropped
        @(posedge clk); #2;
        sel_we = 1'b1; sel_idx = 3'd5;
        @(posedge clk); #2;
        chk(busy == 1'b1, "R5", "busy at second write", busy, 1);
        sel_idx = 3'd1;
        @(posedge clk); #2;
        sel_we = 1'b0;
        repeat (6) @(negedge clk);
        chk_status("R5", 3, 5, 1);

        // R6 / R7: source 5 (period 7), pre 3, post 2
        cfg_write(1'b1, 2, 1);
        expect_period(42, 3, "R6");
        core_period(14, "R7");

        // R6 boundary: source 7 (period 9), divide 8 and 8
        sel_write(7);
        repeat (6) @(negedge clk);
        chk_status("R6", 7, 5, 0);
        cfg_write(1'b1, 7, 7);
        expect_period(576, 2, "R6");
        core_period(72, "R7");

        // R8: clear enable, output silent, state kept, then resume
        cfg_write(1'b0, 7, 7);
        pulses = 0;
        for (int i = 0; i < 700; i++) begin
            @(negedge clk);
            if (out_stb) pulses++;
        end
        chk(pulses == 0, "R8", "pulses while disabled", pulses, 0);
        chk_status("R8", 7, 5, 0);
        cfg_write(1'b1, 7, 7);
        expect_period(576, 2, "R8");

        // R9: stop source 5 (branch B) and write -> stale
        cfg_write(1'b1, 0, 0);
        alive[5] = 1'b0;
        repeat (45) @(posedge clk);
        sel_write(2);
        repeat (4) @(negedge clk);
        chk(stale == 1'b1, "R9", "stale on dead source", stale, 1);
        chk_status("R9", 7, 2, 1);
        sel_write(4);
        repeat (4) @(negedge clk);
        chk(stale == 1'b0, "R9", "stale on live source", stale, 0);
        chk_status("R9", 4, 2, 0);
        expect_period(6, 3, "R2");

        finish_run();
    end

endmodule